// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a two-level page table in memory. The virtual address has three fields. The upper index picks an entry in the root table, whose page number comes from a base input. That entry, if it is present, names the page holding a second-level table. The middle index picks an entry there, and that entry names the frame. The frame number is joined with the untouched page offset to form the result.

A walk starts from a request/acknowledge pair and reads memory through a simple port. The port sends a one-cycle read strobe with an address and waits any number of cycles for a response strobe carrying the data. Each walk ends with a one-cycle result pulse. The pulse carries either the physical address or a fault that names the level at which the walk stopped.

A root entry that is not present ends the walk after a single read. The walker is parameterised in its field widths. The default uses a 32-bit address with 10/10/12 fields and 32-bit entries.

Top module: `pgw_walker`

## Requirements
- R1: While reset is held, and after it is released, `req_ready` is 1 and both `res_valid` and `mem_rd_valid` are 0.
- R2: The first read of a walk goes to address {root_pfn, vaddr[31:22], 2'b00}. This is the root page base plus the top index times 4.
- R3: Bit 0 of an entry is its present flag, and bits 31..12 hold a page number. When the root entry is present, the second read goes to {root_entry[31:12], vaddr[21:12], 2'b00}.
- R4: When the second-level entry is present, the result has `res_fault`=0, `res_fault_lvl`=2'b00 and `res_paddr`={leaf_entry[31:12], vaddr[11:0]}.
- R5: A root entry with bit 0 clear ends the walk with `res_fault`=1 and `res_fault_lvl`=2'b01. No second read is issued.
- R6: A second-level entry with bit 0 clear ends the walk with `res_fault`=1 and `res_fault_lvl`=2'b10, after exactly two reads.
- R7: A request is taken only in a cycle where `req_ready` is 1. `req_ready` stays 0 from the cycle after acceptance through the result cycle. Changes to `req_vaddr` or `req_valid` during a walk have no effect on its reads or its result.
- R8: Every `mem_rd_valid` assertion lasts exactly one cycle. The walker waits an arbitrary number of cycles for `mem_rsp_valid`, and ignores response data outside its waiting states.
- R9: `res_valid` is high for exactly one cycle per walk, and `req_ready` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_pfn | input | 20 | Page number of the root table, sampled when a request is taken |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to take a request |
| mem_rd_valid | output | 1 | One-cycle read strobe |
| mem_rd_addr | output | 32 | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read from memory |
| res_valid | output | 1 | One-cycle result pulse |
| res_paddr | output | 32 | Physical address, zero on a fault |
| res_fault | output | 1 | Walk failed |
| res_fault_lvl | output | 2 | 01 root level, 10 second level, 00 no fault |

## Verification
A result pulse can coincide with a new request that is already waiting. In this design the request must not be taken in the result cycle; it is taken in the idle cycle that follows. The bench holds `req_valid` high through a whole walk and switches the address in the result cycle. It then checks that `req_ready` was low in that cycle and that the second result and its read addresses belong to the second address alone. A separate sweep covers every root index under varied response latencies and holds junk response data with bit 0 set outside the waiting states.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_TOP,
      ST_WT_TOP,
      ST_RD_LEAF,
      ST_WT_LEAF,
      ST_DONE,
      ST_FAULT
   } walk_state_t;

   typedef enum logic [1:0] {
      FLT_NONE = 2'b00,
      FLT_TOP  = 2'b01,
      FLT_LEAF = 2'b10
   } fault_lvl_t;

endpackage

// File: rtl/pgw_entry_addr.sv
// Forms the byte address of a table entry from a table page number and an index.
module pgw_entry_addr #(
   parameter int AW    = 32,
   parameter int OFF_W = 12,
   parameter int IDX_W = 10
) (
   input  logic [AW-OFF_W-1:0] tbl_page,
   input  logic [IDX_W-1:0]    idx,
   output logic [AW-1:0]       ent_addr
);

   localparam int SCALED_W = IDX_W + 2;

   generate
      if (SCALED_W <= OFF_W) begin : g_pack
         // scaled index fits inside the page offset: no carry, plain wiring
         assign ent_addr = {tbl_page, OFF_W'({idx, 2'b00})};
      end else begin : g_add
         // table larger than a page: a real adder is needed
         assign ent_addr = {tbl_page, {OFF_W{1'b0}}} + AW'({idx, 2'b00});
      end
   endgenerate

endmodule

// File: rtl/pgw_fsm.sv
// Walk sequencer: holds the request, tracks the level, builds the result.
module pgw_fsm
   import pgw_pkg::*;
#(
   parameter int VA_W  = 32,
   parameter int PTE_W = 32,
   parameter int OFF_W = 12,
   parameter int L1_W  = 10,
   parameter int L2_W  = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [VA_W-1:0]        req_vaddr,
   input  logic [PTE_W-OFF_W-1:0] root_pfn,
   input  logic                   mem_rsp_valid,
   input  logic [PTE_W-1:0]       mem_rsp_data,
   output logic                   req_ready,
   output logic                   mem_rd_valid,
   output logic                   sel_leaf,
   output logic [PTE_W-OFF_W-1:0] root_q,
   output logic [PTE_W-OFF_W-1:0] page_q,
   output logic [L1_W-1:0]        top_idx,
   output logic [L2_W-1:0]        leaf_idx,
   output logic                   res_valid,
   output logic [PTE_W-1:0]       res_paddr,
   output logic                   res_fault,
   output logic [1:0]             res_fault_lvl
);

   localparam int PG_W = PTE_W - OFF_W;

   walk_state_t      state_q;
   fault_lvl_t       flt_q;
   logic [VA_W-1:0]  va_q;
   logic             present;
   logic [PG_W-1:0]  rsp_page;
   logic             unused_attr_bits;

   assign present          = mem_rsp_data[0];
   assign rsp_page         = mem_rsp_data[PTE_W-1:OFF_W];
   assign unused_attr_bits = ^mem_rsp_data[OFF_W-1:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         flt_q   <= FLT_NONE;
         va_q    <= '0;
         root_q  <= '0;
         page_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               va_q    <= req_vaddr;
               root_q  <= root_pfn;
               state_q <= ST_RD_TOP;
            end
            ST_RD_TOP: state_q <= ST_WT_TOP;
            ST_WT_TOP: if (mem_rsp_valid) begin
               if (present) begin
                  page_q  <= rsp_page;
                  state_q <= ST_RD_LEAF;
               end else begin
                  flt_q   <= FLT_TOP;
                  state_q <= ST_FAULT;
               end
            end
            ST_RD_LEAF: state_q <= ST_WT_LEAF;
            ST_WT_LEAF: if (mem_rsp_valid) begin
               if (present) begin
                  page_q  <= rsp_page;
                  flt_q   <= FLT_NONE;
                  state_q <= ST_DONE;
               end else begin
                  flt_q   <= FLT_LEAF;
                  state_q <= ST_FAULT;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign mem_rd_valid  = (state_q == ST_RD_TOP) || (state_q == ST_RD_LEAF);
   assign sel_leaf      = (state_q == ST_RD_LEAF);
   assign top_idx       = va_q[VA_W-1 -: L1_W];
   assign leaf_idx      = va_q[OFF_W +: L2_W];
   assign res_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
   assign res_fault     = (state_q == ST_FAULT);
   assign res_fault_lvl = (state_q == ST_FAULT) ? flt_q : FLT_NONE;
   assign res_paddr     = (state_q == ST_DONE) ? {page_q, va_q[OFF_W-1:0]} : '0;

   // R8: one read strobe per issue
   assert_read_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |=> !mem_rd_valid);
   // R9: result lasts one cycle
   assert_res_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   // R7: busy right after acceptance
   assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R2: an accepted request launches the root read next cycle
   assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (mem_rd_valid && !sel_leaf));
   // R5: missing root entry faults at level one
   assert_top_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WT_TOP && mem_rsp_valid && !present)
      |=> (res_valid && res_fault && res_fault_lvl == FLT_TOP && !mem_rd_valid));
   // R6: missing leaf entry faults at level two
   assert_leaf_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WT_LEAF && mem_rsp_valid && !present)
      |=> (res_valid && res_fault && res_fault_lvl == FLT_LEAF));
   // R4: frame of the leaf entry appears in the result
   assert_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WT_LEAF && mem_rsp_valid && present)
      |=> (res_valid && !res_fault && res_paddr[PTE_W-1:OFF_W] == $past(rsp_page)));

endmodule

// File: rtl/pgw_walker.sv
// Two-level page table walker, top level.
module pgw_walker #(
   parameter int VA_W  = 32,
   parameter int PTE_W = 32,
   parameter int OFF_W = 12,
   parameter int L1_W  = 10,
   parameter int L2_W  = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [PTE_W-OFF_W-1:0] root_pfn,
   input  logic                   req_valid,
   input  logic [VA_W-1:0]        req_vaddr,
   output logic                   req_ready,
   output logic                   mem_rd_valid,
   output logic [PTE_W-1:0]       mem_rd_addr,
   input  logic                   mem_rsp_valid,
   input  logic [PTE_W-1:0]       mem_rsp_data,
   output logic                   res_valid,
   output logic [PTE_W-1:0]       res_paddr,
   output logic                   res_fault,
   output logic [1:0]             res_fault_lvl
);

   localparam int PG_W  = PTE_W - OFF_W;
   localparam int IDX_W = (L1_W > L2_W) ? L1_W : L2_W;

   generate
      if (VA_W != L1_W + L2_W + OFF_W) begin : g_bad_split
         $error("address fields do not add up to VA_W");
      end
      if (PTE_W <= OFF_W + 1) begin : g_bad_entry
         $error("entry too narrow for a page number and a present flag");
      end
      if (IDX_W + 2 > PTE_W) begin : g_bad_index
         $error("index too wide for the entry address");
      end
   endgenerate

   logic             sel_leaf;
   logic [PG_W-1:0]  root_q;
   logic [PG_W-1:0]  page_q;
   logic [L1_W-1:0]  top_idx;
   logic [L2_W-1:0]  leaf_idx;
   logic [PG_W-1:0]  tbl_page;
   logic [IDX_W-1:0] ent_idx;

   pgw_fsm #(
      .VA_W (VA_W), .PTE_W(PTE_W), .OFF_W(OFF_W), .L1_W(L1_W), .L2_W(L2_W)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_vaddr     (req_vaddr),
      .root_pfn      (root_pfn),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .req_ready     (req_ready),
      .mem_rd_valid  (mem_rd_valid),
      .sel_leaf      (sel_leaf),
      .root_q        (root_q),
      .page_q        (page_q),
      .top_idx       (top_idx),
      .leaf_idx      (leaf_idx),
      .res_valid     (res_valid),
      .res_paddr     (res_paddr),
      .res_fault     (res_fault),
      .res_fault_lvl (res_fault_lvl)
   );

   // one shared address unit, steered by the current level
   assign tbl_page = sel_leaf ? page_q : root_q;
   assign ent_idx  = sel_leaf ? IDX_W'(leaf_idx) : IDX_W'(top_idx);

   pgw_entry_addr #(
      .AW (PTE_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
   ) u_addr (
      .tbl_page (tbl_page),
      .idx      (ent_idx),
      .ent_addr (mem_rd_addr)
   );

   // R2/R3: entry addresses are word aligned
   assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00));

endmodule

// File: tb/tb_pgw_walker.sv
module tb_pgw_walker;

   localparam logic [19:0] ROOT_PG = 20'h00100;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [19:0] root_pfn;
   logic        req_valid;
   logic [31:0] req_vaddr;
   logic        req_ready;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        res_valid;
   logic [31:0] res_paddr;
   logic        res_fault;
   logic [1:0]  res_fault_lvl;

   int          total = 0;
   int          bad   = 0;
   int          rd_cnt = 0;
   int          lat_sel = 0;
   logic [31:0] rec_addr [2];

   always #10 clk = ~clk;

   pgw_walker dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .root_pfn      (root_pfn),
      .req_valid     (req_valid),
      .req_vaddr     (req_vaddr),
      .req_ready     (req_ready),
      .mem_rd_valid  (mem_rd_valid),
      .mem_rd_addr   (mem_rd_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .res_valid     (res_valid),
      .res_paddr     (res_paddr),
      .res_fault     (res_fault),
      .res_fault_lvl (res_fault_lvl)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // table contents, computed: root entry i points at page 0x200+i,
   // present unless i%3==2; leaf (i,j) present unless (i+j)%5==4
   function automatic logic [31:0] mem_model(input logic [31:0] a);
      logic [19:0] pg = a[31:12];
      logic [19:0] frame;
      int i;
      int j;
      if (pg == ROOT_PG) begin
         i = int'(a[11:2]);
         if (i % 3 == 2) return {20'h00200 + 20'(i), 12'hFFE};
         return {20'h00200 + 20'(i), 12'h001};
      end
      if (pg >= 20'h00200 && pg < 20'h00600) begin
         i = int'(pg - 20'h00200);
         j = int'(a[11:2]);
         frame = 20'(i * 37 + j * 11 + 32'h50000);
         if ((i + j) % 5 == 4) return {frame, 12'hFFE};
         return {frame, 12'h801};
      end
      return 32'hFFFF_F000;
   endfunction

   function automatic void exp_walk(input logic [31:0] va, output logic [31:0] pa,
                                    output logic flt, output logic [1:0] lvl,
                                    output int nrd, output logic [31:0] a0,
                                    output logic [31:0] a1);
      logic [31:0] t;
      logic [31:0] l;
      a0 = {ROOT_PG, va[31:22], 2'b00};
      t  = mem_model(a0);
      a1 = '0;
      pa = '0;
      if (!t[0]) begin
         flt = 1'b1; lvl = 2'b01; nrd = 1;
      end else begin
         a1  = {t[31:12], va[21:12], 2'b00};
         l   = mem_model(a1);
         nrd = 2;
         if (!l[0]) begin
            flt = 1'b1; lvl = 2'b10;
         end else begin
            flt = 1'b0; lvl = 2'b00; pa = {l[31:12], va[11:0]};
         end
      end
   endfunction

   // memory responder with latency 1..3 cycles; junk data outside responses
   initial begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 32'hFFFF_FFFF;
      forever begin
         if (mem_rd_valid !== 1'b1) @(negedge clk);
         else begin
            logic [31:0] a;
            a = mem_rd_addr;
            if (rd_cnt < 2) rec_addr[rd_cnt] = a;
            rd_cnt++;
            @(negedge clk);
            chk(mem_rd_valid == 1'b0, "R8", "read strobe width", 32'(mem_rd_valid), 32'h0);
            repeat (lat_sel % 3) @(negedge clk);
            lat_sel++;
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_model(a);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = 32'hFFFF_FFFF;
         end
      end
   end

   task automatic wait_result();
      for (int n = 0; n < 60; n++) begin
         if (res_valid === 1'b1) return;
         @(negedge clk);
      end
      chk(1'b0, "R9", "result never arrived", 32'h0, 32'h1);
   endtask

   task automatic judge(input logic [31:0] va);
      logic [31:0] pa, a0, a1;
      logic        flt;
      logic [1:0]  lvl;
      int          nrd;
      exp_walk(va, pa, flt, lvl, nrd, a0, a1);
      chk(rec_addr[0] == a0, "R2", "root entry address", rec_addr[0], a0);
      chk(rd_cnt == nrd, flt && lvl == 2'b01 ? "R5" : "R3", "read count",
          32'(rd_cnt), 32'(nrd));
      if (nrd == 2) chk(rec_addr[1] == a1, "R3", "leaf entry address", rec_addr[1], a1);
      chk(res_fault == flt, "R4", "fault flag", 32'(res_fault), 32'(flt));
      chk(res_fault_lvl == lvl, lvl == 2'b10 ? "R6" : "R5", "fault level",
          32'(res_fault_lvl), 32'(lvl));
      if (!flt) chk(res_paddr == pa, "R4", "physical address", res_paddr, pa);
   endtask

   task automatic run_walk(input logic [31:0] va);
      rd_cnt    = 0;
      req_vaddr = va;
      req_valid = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b0, "R7", "busy after accept", 32'(req_ready), 32'h0);
      req_valid = 1'b0;
      req_vaddr = ~va;
      wait_result();
      judge(va);
      @(negedge clk);
      chk(res_valid == 1'b0, "R9", "result width", 32'(res_valid), 32'h0);
      chk(req_ready == 1'b1, "R9", "idle after result", 32'(req_ready), 32'h1);
   endtask

   // request held through a walk; a second address presented in the result cycle
   task automatic run_overlap(input logic [31:0] va_a, input logic [31:0] va_b);
      rd_cnt    = 0;
      req_vaddr = va_a;
      req_valid = 1'b1;
      @(negedge clk);
      req_vaddr = 32'h1234_5678;
      wait_result();
      judge(va_a);
      chk(req_ready == 1'b0, "R7", "not ready in result cycle", 32'(req_ready), 32'h0);
      req_vaddr = va_b;
      rd_cnt    = 0;
      @(negedge clk);
      chk(res_valid == 1'b0, "R9", "single result pulse", 32'(res_valid), 32'h0);
      chk(rd_cnt == 0, "R7", "no read in idle cycle", 32'(rd_cnt), 32'h0);
      @(negedge clk);
      req_valid = 1'b0;
      wait_result();
      judge(va_b);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R9", "watchdog expired", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_vaddr = '0;
      root_pfn  = ROOT_PG;
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 32'h1);
      chk(res_valid == 1'b0, "R1", "no result in reset", 32'(res_valid), 32'h0);
      chk(mem_rd_valid == 1'b0, "R1", "no read in reset", 32'(mem_rd_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && res_valid == 1'b0 && mem_rd_valid == 1'b0, "R1",
          "idle after reset", {29'h0, req_ready, res_valid, mem_rd_valid}, 32'h4);

      // corners: R5 root absent, R6 leaf absent, R4 extreme fields
      run_walk({10'd2, 10'd0, 12'h000});
      run_walk({10'd0, 10'd4, 12'h123});
      run_walk(32'h0000_0000);
      run_walk(32'hFFFF_FFFF);
      run_walk({10'd1023, 10'd0, 12'hFFF});

      // every root index, varied leaf index and offset
      for (int i = 0; i < 1024; i++) begin
         run_walk({10'(i), 10'((i * 7 + 3) % 1024), 12'((i * 13) & 12'hFFF)});
      end

      run_overlap({10'd4, 10'd11, 12'h3A5}, {10'd7, 10'd100, 12'hFFF});
      run_overlap({10'd8, 10'd1, 12'h010}, {10'd5, 10'd2, 12'h7FF});

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule